// File: doc/BRIEF.md
# Sliding-Window General-Purpose Register File

This block is a register file for a three-operand datapath. It has a large physical store, but software reaches only a small slice of it at any time. Short register indices address that slice, and a window number selects which slice is live. Each cycle, two operands are read through combinational ports and one result is written on the rising clock edge.

A procedure call is a single-cycle strobe. It advances the live window to the next group of registers, so the callee starts on registers the caller never touched. A return strobe steps the window back, and the caller finds its values exactly as it left them. No save or restore traffic to memory is needed. When a call is issued from the topmost window, or a return from window zero, the window stays where it is and a one-cycle indication is raised instead. Spilling windows to memory is left to the surrounding logic.

Top module: `wrf_top`

## Requirements
- R1: After synchronous reset, the live window is window 0 (logical index i maps to physical register i). Both range indications are low. Stored register contents are not cleared by reset.
- R2: Both read ports return, combinationally, the stored value of physical register `window*8 + index` for the window live in the current cycle.
- R3: A call (call_i=1, ret_i=0) issued in the last window (window 15) leaves the window unchanged. It raises ovf_o for exactly the one cycle that follows the strobe.
- R4: A return (ret_i=1, call_i=0) issued in window 0 leaves the window unchanged. It raises unf_o for exactly the one cycle that follows the strobe.
- R5: A call from any window below the last moves to the next window, so the same logical index then addresses a different physical register.
- R6: A return from any window above 0 moves back one window. Every register of the caller's window reads back unchanged.
- R7: A write issued in the same cycle as a call or return lands in the window that was live in that cycle.
- R8: call_i and ret_i both high in one cycle cause no window change and no ovf_o or unf_o pulse.
- R9: A read of the register being written in the same cycle returns the previously stored value; there is no write-to-read bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe: advance the window |
| ret_i | input | 1 | Procedure return strobe: step the window back |
| rd_a_idx | input | 3 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 3 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Logical index for the write |
| wr_data | input | DATA_W | Write data |
| ovf_o | output | 1 | One-cycle pulse: call refused at the last window |
| unf_o | output | 1 | One-cycle pulse: return refused at window 0 |

## Verification
The hardest condition to reach from the ports is a call at the top window. It needs fifteen successful calls in a row first, and the window number is never output. The stimulus therefore climbs through every window, writing a distinct tag into each one on the way. It then reads back the tags to show where the window stands when the refused call arrives and after the return that follows it. The coincident cases are handled by the vector table: write plus call, call plus return, and read of the register being written.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  // Operation requested on the window pointer in one cycle
  typedef enum logic [1:0] {
    WIN_HOLD = 2'b00,
    WIN_UP   = 2'b01,
    WIN_DOWN = 2'b10
  } win_op_e;

  function automatic win_op_e decode_op(input logic call_s, input logic ret_s);
    if (call_s && !ret_s) return WIN_UP;
    if (ret_s && !call_s) return WIN_DOWN;
    return WIN_HOLD;
  endfunction
endpackage

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
  parameter int NUM_WIN   = 16,
  parameter int WIN_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 call_i,
  input  logic                 ret_i,
  output logic [WIN_IDX_W-1:0] win_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  import wrf_pkg::*;

  localparam logic [WIN_IDX_W-1:0] LAST_WIN = WIN_IDX_W'(NUM_WIN - 1);

  win_op_e op;
  logic [WIN_IDX_W-1:0] win_q;

  assign op    = decode_op(call_i, ret_i);
  assign win_o = win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      unique case (op)
        WIN_UP: begin
          if (win_q == LAST_WIN) ovf_o <= 1'b1;
          else                   win_q <= win_q + 1'b1;
        end
        WIN_DOWN: begin
          if (win_q == '0) unf_o <= 1'b1;
          else             win_q <= win_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
  parameter int WIN_IDX_W = 4,
  parameter int IDX_W     = 3
) (
  input  logic [WIN_IDX_W-1:0]       win_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [WIN_IDX_W+IDX_W-1:0] addr_o
);
  // Window size is a power of two, so base + index is a concatenation
  assign addr_o = {win_i, idx_i};
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [AW-1:0]     ra_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic [AW-1:0]     rb_i,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  // Asynchronous reads: distributed RAM, old data during a write
  assign rd_a_o = mem[ra_i];
  assign rd_b_o = mem[rb_i];
endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
  parameter int DATA_W    = 32,
  parameter int PHYS_REGS = 128,
  parameter int WIN_REGS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [2:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [2:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int IDX_W     = $clog2(WIN_REGS);
  localparam int PHYS_AW   = $clog2(PHYS_REGS);
  localparam int NUM_WIN   = PHYS_REGS / WIN_REGS;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);
  localparam int NPORTS    = 3; // write, read A, read B

  logic [WIN_IDX_W-1:0] win_sel;
  logic [IDX_W-1:0]     lidx  [NPORTS];
  logic [PHYS_AW-1:0]   paddr [NPORTS];

  assign lidx[0] = IDX_W'(wr_idx);
  assign lidx[1] = IDX_W'(rd_a_idx);
  assign lidx[2] = IDX_W'(rd_b_idx);

  wrf_window_ctrl #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) i_win (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .win_o(win_sel), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    wrf_addr_map #(.WIN_IDX_W(WIN_IDX_W), .IDX_W(IDX_W)) i_map (
      .win_i(win_sel), .idx_i(lidx[p]), .addr_o(paddr[p])
    );
  end

  wrf_store #(.DATA_W(DATA_W), .DEPTH(PHYS_REGS), .AW(PHYS_AW)) i_store (
    .clk(clk), .we_i(wr_en), .wa_i(paddr[0]), .wd_i(wr_data),
    .ra_i(paddr[1]), .rd_a_o(rd_a_data),
    .rb_i(paddr[2]), .rd_b_o(rd_b_data)
  );
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int NUM_WIN   = 16,
  parameter int WIN_IDX_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 call_i,
  input logic                 ret_i,
  input logic                 ovf_o,
  input logic                 unf_o,
  input logic [WIN_IDX_W-1:0] win
);
  localparam logic [WIN_IDX_W-1:0] LAST_WIN = WIN_IDX_W'(NUM_WIN - 1);

  assert_ovf_at_top_R3: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && win == LAST_WIN) |=> (ovf_o && win == LAST_WIN));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> $past(call_i && !ret_i));

  assert_unf_at_bottom_R4: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && win == '0) |=> (unf_o && win == '0));

  assert_unf_cause_R4: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> $past(ret_i && !call_i));

  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && win != LAST_WIN) |=> (win == $past(win) + 1'b1) && !ovf_o);

  assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && win != '0) |=> (win == $past(win) - 1'b1) && !unf_o);

  assert_both_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> ($stable(win) && !ovf_o && !unf_o));

  assert_no_dual_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));
endmodule

bind wrf_top wrf_checker #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) i_chk (
  .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
  .ovf_o(ovf_o), .unf_o(unf_o), .win(win_sel)
);

// File: tb/test_wrf_top.sv
module test_wrf_top;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst, call_i, ret_i, wr_en, ovf_o, unf_o;
  logic [2:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  wrf_top i_wrf_top (.*);

  typedef struct packed {
    logic          call, ret, we;
    logic [2:0]    widx;
    logic [DW-1:0] wdata;
    logic [2:0]    ra, rb;
    logic          chk;
    logic [DW-1:0] ea, eb;
    logic          eovf, eunf;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    // c  r  we idx data          ra rb chk ea            eb            ovf unf
    '{1'b0,1'b0,1'b1,3'd1,32'h11111111,3'd0,3'd0,1'b0,32'h0,32'h0,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,3'd2,32'h22222222,3'd1,3'd1,1'b1,32'h11111111,32'h11111111,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,3'd1,32'hAAAA0001,3'd1,3'd2,1'b1,32'h11111111,32'h22222222,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,3'd1,32'h33333333,3'd0,3'd0,1'b0,32'h0,32'h0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd0,32'h0,       3'd1,3'd1,1'b1,32'h33333333,32'h33333333,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,3'd0,32'h0,       3'd1,3'd2,1'b1,32'hAAAA0001,32'h22222222,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,3'd0,32'h0,       3'd1,3'd2,1'b1,32'hAAAA0001,32'h22222222,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,3'd0,32'h0,       3'd1,3'd1,1'b1,32'hAAAA0001,32'hAAAA0001,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,3'd0,32'h0,       3'd1,3'd1,1'b1,32'hAAAA0001,32'hAAAA0001,1'b0,1'b0}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, let combinational reads settle, then check
  task automatic drive(input logic c, input logic r, input logic we,
                       input logic [2:0] wi, input logic [DW-1:0] wd,
                       input logic [2:0] ra, input logic [2:0] rb);
    @(negedge clk);
    call_i = c; ret_i = r; wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb;
    #1;
  endtask

  initial begin
    rst = 1'b1; call_i = 0; ret_i = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    rd_a_idx = 0; rd_b_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ovf after reset", 32'(ovf_o), 32'd0);
    check("R1 unf after reset", 32'(unf_o), 32'd0);
    rst = 1'b0;

    // Vector table: R2 reads, R9 no bypass, R7 write with call, R5, R6, R8, R4
    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].call, TBL[v].ret, TBL[v].we, TBL[v].widx, TBL[v].wdata,
            TBL[v].ra, TBL[v].rb);
      if (TBL[v].chk) begin
        check($sformatf("R2/R5/R6/R7/R9 vec %0d port A", v), rd_a_data, TBL[v].ea);
        check($sformatf("R2/R5/R6/R7/R9 vec %0d port B", v), rd_b_data, TBL[v].eb);
      end
      check($sformatf("R3/R8 vec %0d ovf", v), 32'(ovf_o), 32'(TBL[v].eovf));
      check($sformatf("R4/R8 vec %0d unf", v), 32'(unf_o), 32'(TBL[v].eunf));
    end

    // Climb through all windows tagging logical 0 in each (R5)
    for (int w = 0; w < 16; w++) begin
      drive(1'b1, 1'b0, 1'b1, 3'd0, 32'hC0DE0000 + 32'(w), 3'd0, 3'd0);
      if (w > 0) check("R5 fresh window pulse", 32'(ovf_o), 32'd0);
    end
    // The last call above was at window 15: refused
    drive(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd0, 3'd0);
    check("R3 ovf pulse", 32'(ovf_o), 32'd1);
    check("R3 window held", rd_a_data, 32'hC0DE000F);
    drive(1'b0, 1'b1, 1'b0, 3'd0, 32'h0, 3'd0, 3'd0);
    check("R3 ovf one cycle", 32'(ovf_o), 32'd0);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd0, 3'd0);
    check("R6 back to window 14", rd_a_data, 32'hC0DE000E);
    check("R6 no unf", 32'(unf_o), 32'd0);

    // Reset returns to window 0, contents kept (R1)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 3'd0, 32'h0, 3'd1, 3'd0);
    check("R1 window 0 after reset", rd_a_data, 32'hAAAA0001);
    check("R1 window 0 tag", rd_b_data, 32'hC0DE0000);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd1, 3'd1);
    check("R4 unf after reset return", 32'(unf_o), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule